// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two `OP_W`-bit operands over several clocks and returns the full `2*OP_W`-bit product. It has a single wide adder and three registers. The first is an accumulator that starts at zero. The second is a double-width multiplicand register that moves one place toward the MSB on every step. The third is a multiplier register that moves one place toward the LSB on every step. On each step, the current low bit of the multiplier decides whether the multiplicand is added into the accumulator. The add and both shifts complete in the same clock.

A mode input chooses between unsigned and two's complement operands. In two's complement mode, each negative operand is first turned into its magnitude. The magnitudes are then multiplied as unsigned values. If exactly one operand was negative, the result is negated just before it is stored. The caller raises `start` while the block is idle. `busy` is then high while the steps run, and `done` pulses for one cycle once `product` holds the new result.

Top module: `shiftadd_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: With `signed_mode`=0, the operands are unsigned and `product` equals their exact unsigned product in 2*OP_W bits, so no result can overflow. For OP_W=4, 0110×0101 gives 00011110 and 1111×0101 gives 01001011.
- R3: A `start` seen high at a clock edge while idle makes `busy` high for exactly OP_W cycles, beginning in the cycle after that edge.
- R4: `done` goes high for exactly one cycle, in the cycle right after the last `busy` cycle, and `product` already holds the new result in that cycle.
- R5: A `start` seen while `busy` is high is ignored. The running multiply keeps its operands and its timing.
- R6: `op_a`, `op_b` and `signed_mode` are captured at the accepted start. Changes to them while `busy` is high do not change the result.
- R7: `product` changes only at the clock edge that raises `done`. It keeps its value through the next multiply until that multiply completes.
- R8: With `signed_mode`=1, the operands are two's complement and `product` is their two's complement product in 2*OP_W bits. The result is negative exactly when the operand signs differ and neither operand is zero.
- R9: In two's complement mode, the most negative operand, -2^(OP_W-1), is handled through the magnitude 2^(OP_W-1). The products (-2^(OP_W-1))², -2^(OP_W-1)×(2^(OP_W-1)-1) and -2^(OP_W-1)×1 all come out exact.
- R10: A `start` in the same cycle as `done` is accepted, so multiplies can run back to back every OP_W+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a multiply when the block is idle |
| signed_mode | input | 1 | 1: two's complement operands, 0: unsigned |
| op_a | input | OP_W | Multiplicand |
| op_b | input | OP_W | Multiplier |
| busy | output | 1 | High while steps are running |
| done | output | 1 | One-cycle pulse when a new product is available |
| product | output | 2*OP_W | Result of the last completed multiply |

## Verification
The bench builds the block with OP_W=4 and two's complement support enabled. At that width every operand pair can be run in both modes, which is 512 multiplies. That covers the most negative operand against all others, all-ones unsigned operands, and zero against signs of either polarity, without sampling. Because the multiplies run back to back, every start lands in a `done` cycle. Extra runs add stray starts and operand changes in the middle of a multiply.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;

   typedef enum logic [0:0] {
      MS_IDLE = 1'b0,
      MS_RUN  = 1'b1
   } mul_state_e;

   function automatic int unsigned step_cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/shiftadd_mul_prep.sv
module shiftadd_mul_prep #(
   parameter int unsigned OP_W      = 8,
   parameter bit          SIGNED_EN = 1'b1
) (
   input  logic              signed_mode,
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   output logic [OP_W-1:0]   mag_a,
   output logic [OP_W-1:0]   mag_b,
   output logic              neg_res
);

   localparam int unsigned MSB = OP_W - 1;

   generate
      if (SIGNED_EN) begin : g_twos
         logic a_neg, b_neg;
         assign a_neg   = signed_mode & op_a[MSB];
         assign b_neg   = signed_mode & op_b[MSB];
         // the most negative value maps to 2^(OP_W-1) read as unsigned
         assign mag_a   = a_neg ? (~op_a + 1'b1) : op_a;
         assign mag_b   = b_neg ? (~op_b + 1'b1) : op_b;
         assign neg_res = a_neg ^ b_neg;
      end else begin : g_unsigned_only
         assign mag_a   = op_a;
         assign mag_b   = op_b;
         assign neg_res = signed_mode & 1'b0;
      end
   endgenerate

endmodule

// File: rtl/shiftadd_mul_ctrl.sv
module shiftadd_mul_ctrl
   import shiftadd_mul_pkg::*;
#(
   parameter int unsigned OP_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic fin,
   output logic busy,
   output logic done
);

   localparam int unsigned CNT_W = step_cnt_w(OP_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_W - 1);

   mul_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   assign busy = (state_q == MS_RUN);
   assign load = (state_q == MS_IDLE) && start;
   assign step = busy;
   assign fin  = busy && (cnt_q == LAST);
   assign done = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= MS_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= fin;
         unique case (state_q)
            MS_IDLE: begin
               if (start) begin
                  state_q <= MS_RUN;
                  cnt_q   <= '0;
               end
            end
            MS_RUN: begin
               if (cnt_q == LAST) begin
                  state_q <= MS_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= MS_IDLE;
         endcase
      end
   end

   AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q <= LAST)); // R3

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4

   AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R4

   AST_START_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !fin) |=> (busy && (cnt_q == $past(cnt_q) + 1'b1))); // R5

endmodule

// File: rtl/shiftadd_mul_dp.sv
module shiftadd_mul_dp #(
   parameter int unsigned OP_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                step,
   input  logic [OP_W-1:0]     mag_a,
   input  logic [OP_W-1:0]     mag_b,
   input  logic                neg_in,
   output logic [2*OP_W-1:0]   sum_now,
   output logic                neg_q
);

   localparam int unsigned PW = 2 * OP_W;

   logic [PW-1:0]   mcand_q;
   logic [OP_W-1:0] mplier_q;
   logic [PW-1:0]   acc_q;

   // single adder; the multiplier LSB gates its second operand
   assign sum_now = acc_q + (mplier_q[0] ? mcand_q : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         mplier_q <= '0;
         acc_q    <= '0;
         neg_q    <= 1'b0;
      end else if (load) begin
         mcand_q  <= {{OP_W{1'b0}}, mag_a};
         mplier_q <= mag_b;
         acc_q    <= '0;
         neg_q    <= neg_in;
      end else if (step) begin
         acc_q    <= sum_now;
         mcand_q  <= mcand_q << 1;
         mplier_q <= mplier_q >> 1;
      end
   end

   AST_LOAD_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (acc_q == '0)); // R2

   AST_MPLIER_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (mplier_q == ($past(mplier_q) >> 1))); // R2

   AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> ($stable(mcand_q) && $stable(mplier_q) && $stable(neg_q))); // R6

endmodule

// File: rtl/shiftadd_mul_fix.sv
module shiftadd_mul_fix #(
   parameter int unsigned PW        = 16,
   parameter bit          SIGNED_EN = 1'b1
) (
   input  logic [PW-1:0] mag_prod,
   input  logic          neg,
   output logic [PW-1:0] res
);

   generate
      if (SIGNED_EN) begin : g_negate
         assign res = neg ? (~mag_prod + 1'b1) : mag_prod;
      end else begin : g_pass
         assign res = mag_prod ^ {PW{neg & 1'b0}};
      end
   endgenerate

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
   parameter int unsigned OP_W      = 8,
   parameter bit          SIGNED_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  signed_mode,
   input  logic [OP_W-1:0]       op_a,
   input  logic [OP_W-1:0]       op_b,
   output logic                  busy,
   output logic                  done,
   output logic [2*OP_W-1:0]     product
);

   localparam int unsigned PW = 2 * OP_W;

   generate
      if (OP_W < 2) begin : g_bad_width
         $error("shiftadd_mul: OP_W must be at least 2");
      end
   endgenerate

   logic            load, step, fin;
   logic [OP_W-1:0] mag_a, mag_b;
   logic            neg_in, neg_q;
   logic [PW-1:0]   sum_now, fixed;
   logic [PW-1:0]   product_q;

   shiftadd_mul_prep #(.OP_W(OP_W), .SIGNED_EN(SIGNED_EN)) prep_i (
      .signed_mode (signed_mode),
      .op_a        (op_a),
      .op_b        (op_b),
      .mag_a       (mag_a),
      .mag_b       (mag_b),
      .neg_res     (neg_in)
   );

   shiftadd_mul_ctrl #(.OP_W(OP_W)) ctrl_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .fin   (fin),
      .busy  (busy),
      .done  (done)
   );

   shiftadd_mul_dp #(.OP_W(OP_W)) dp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .mag_a   (mag_a),
      .mag_b   (mag_b),
      .neg_in  (neg_in),
      .sum_now (sum_now),
      .neg_q   (neg_q)
   );

   shiftadd_mul_fix #(.PW(PW), .SIGNED_EN(SIGNED_EN)) fix_i (
      .mag_prod (sum_now),
      .neg      (neg_q),
      .res      (fixed)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         product_q <= '0;
      end else if (fin) begin
         product_q <= fixed;
      end
   end

   assign product = product_q;

   AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> $stable(product)); // R7

   AST_NEG_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && neg_q && (product != '0)) |-> product[PW-1]); // R8

   AST_NO_START_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |-> !load); // R5

endmodule

// File: tb/shiftadd_mul_tb_top.sv
`timescale 1ns/1ps
module shiftadd_mul_tb_top;

   localparam int W  = 4;
   localparam int PW = 2 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          signed_mode = 1'b0;
   logic [W-1:0]  op_a = '0;
   logic [W-1:0]  op_b = '0;
   logic          busy, done;
   logic [PW-1:0] product;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   string tag = "R1";
   bit cmp_en = 1'b0;

   always #2 clk = ~clk;

   shiftadd_mul #(.OP_W(W), .SIGNED_EN(1'b1)) dut_i (
      .clk (clk), .rst_n (rst_n), .start (start), .signed_mode (signed_mode),
      .op_a (op_a), .op_b (op_b), .busy (busy), .done (done), .product (product)
   );

   function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic s);
      longint x, y, p;
      x = longint'(a);
      y = longint'(b);
      if (s) begin
         if (a[W-1]) x = x - (longint'(1) << W);
         if (b[W-1]) y = y - (longint'(1) << W);
      end
      p = x * y;
      return p[PW-1:0];
   endfunction

   // behavioural cycle model
   bit            m_busy = 0, m_done = 0;
   int            m_cnt = 0;
   logic [PW-1:0] m_prod = '0, m_pend = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_cnt = 0; m_prod = '0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
               m_busy = 0; m_done = 1; m_prod = m_pend;
            end
         end else if (start) begin
            m_busy = 1; m_cnt = W; m_pend = ref_mul(op_a, op_b, signed_mode);
         end
      end
   end

   task automatic check(input string t, input string what, input logic [PW-1:0] act,
                        input logic [PW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         check((tag == "R2" || tag == "R8") ? "R3" : tag, "busy", PW'(busy), PW'(m_busy));
         check((tag == "R2" || tag == "R8") ? "R4" : tag, "done", PW'(done), PW'(m_done));
         check((tag == "R2" || tag == "R8") ? "R7" : tag, "product", product, m_prod);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected<=100000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ends in the done cycle of the operation, inputs sampled at negedges
   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                         input string t, input int mode);
      logic [PW-1:0] e;
      e = ref_mul(a, b, s);
      start = 1'b1; op_a = a; op_b = b; signed_mode = s;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < W; k++) begin
         if (k == 1 && mode == 1) begin
            start = 1'b1; op_a = ~a; op_b = ~b; signed_mode = ~s; // R5 stray start
         end else if (k == 1 && mode == 2) begin
            op_a = a + 1'b1; op_b = ~b; signed_mode = ~s;         // R6 operand change
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      check(t, "done", PW'(done), PW'(1));
      check(t, "result", product, e);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "busy", PW'(busy), '0);
      check("R1", "done", PW'(done), '0);
      check("R1", "product", product, '0);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      @(negedge clk);

      tag = "R2";
      run_op(4'b0110, 4'b0101, 1'b0, "R2", 0);
      check("R2", "0110x0101", product, 8'b0001_1110);
      run_op(4'b1111, 4'b0101, 1'b0, "R2", 0);
      check("R2", "1111x0101", product, 8'b0100_1011);
      run_op(4'b1111, 4'b1111, 1'b0, "R2", 0);

      tag = "R9";
      run_op(4'b1000, 4'b1000, 1'b1, "R9", 0);
      check("R9", "-8x-8", product, 8'd64);
      run_op(4'b1000, 4'b0111, 1'b1, "R9", 0);
      check("R9", "-8x7", product, 8'hC8);
      run_op(4'b1000, 4'b0001, 1'b1, "R9", 0);
      check("R9", "-8x1", product, 8'hF8);

      tag = "R5";
      run_op(4'b0011, 4'b0101, 1'b0, "R5", 1);
      run_op(4'b1101, 4'b0110, 1'b1, "R5", 1);
      tag = "R6";
      run_op(4'b0111, 4'b1001, 1'b0, "R6", 2);
      run_op(4'b1010, 4'b0011, 1'b1, "R6", 2);

      tag = "R7";
      repeat (5) @(negedge clk);
      check("R7", "idle hold", product, ref_mul(4'b1010, 4'b0011, 1'b1));
      start = 1'b1; op_a = 4'd2; op_b = 4'd3; signed_mode = 1'b0;
      @(negedge clk);
      start = 1'b0;
      check("R7", "hold while busy", product, ref_mul(4'b1010, 4'b0011, 1'b1));
      repeat (W) @(negedge clk);
      check("R7", "new value", product, 8'd6);

      // exhaustive, back to back: each start lands in a done cycle (R10)
      for (int s = 0; s < 2; s++) begin
         tag = (s == 0) ? "R2" : "R8";
         for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
               run_op(a[W-1:0], b[W-1:0], s[0], (s == 0) ? "R10" : "R8", 0);
            end
         end
      end

      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule